// File: doc/BRIEF.md
# Flash Block Write-Protect Controller

This block stands between software-issued flash control requests and the high-voltage enable that drives a flash array's program and erase operations. It keeps a one-byte protect value, loaded from non-volatile storage, and turns it into the start of a protected address window that reaches to the top of the 16-bit space. Each target address is compared against that window. The controller sequences the program-mode, erase-mode and high-voltage-enable controls and refuses high voltage when the target is protected, when both modes are requested together, or when the protect byte was not read between mode selection and the enable request.

The sequencer has six states. ST_IDLE has no mode selected. ST_MODE has one mode selected and is waiting for the protect-byte read. ST_ARMED means the read has happened and high voltage may be requested. ST_HV drives high voltage. ST_ILLEGAL is entered when both modes are requested. ST_BLOCKED holds after a refused enable until the mode bits are cleared.

The transitions are as follows:
- idle-to-mode is a single-mode write.
- mode-to-armed is the protect-byte read.
- armed-to-hv is a granted enable write.
- mode-to-blocked and armed-to-blocked are refused enables.
- hv-to-blocked is a target moving into protection.
- hv-to-idle is a write clearing the enable or the modes.
- any-to-illegal is a write with both modes.
- any-to-idle is a write with both modes clear.
- armed-to-mode and mode-to-mode are a change of the selected mode.

The protect byte is stored at address 16'hFFCF. It changes through a high-voltage operation aimed at that address: a program operation ANDs the new data into the byte, and an erase operation sets it to 8'hFF.

Top module: `fwp_ctrl`

## Requirements
- R1: The protected window starts at {2'b11, protect_byte, 6'b000000}, which is output on prot_start_o. For any protect byte other than 8'h00 and 8'hFF, an address is protected (tgt_prot_o=1) exactly when it is greater than or equal to that start, up to and including 16'hFFFF.
- R2: With protect byte 8'hFF, no address is protected.
- R3: With protect byte 8'h00, every address is protected.
- R4: A request for high voltage (ctl_wr with ctl_hven=1) whose target is protected is refused. hven_o stays 0 and viol_o becomes 1. The one exception is that target 16'hFFCF is granted while hv_test=1.
- R5: A high-voltage request made without a protect-byte read (prot_rd pulse) after the latest mode selection is refused. The controller then stays blocked, with hven_o low, until a write clears both mode bits, even if a read and another request follow.
- R6: A write with ctl_pgm=1 and ctl_erase=1 is illegal. In that case pgm_o and erase_o both read 0, hven_o stays 0, and any high-voltage request made there sets viol_o.
- R7: In ST_HV with target 16'hFFCF, an op_commit pulse writes the protect byte. In program mode the new byte is the old byte AND op_data. In erase mode the new byte is 8'hFF. While the byte is not 8'hFF, reaching ST_HV for that address requires hv_test=1.
- R8: Reset puts the sequencer in ST_IDLE with pgm_o, erase_o, hven_o and viol_o at 0, and leaves the protect byte unchanged.
- R9: viol_o is sticky and is cleared by a viol_clr pulse. A refusal in the same cycle as the clear leaves it at 1.
- R10: A write clearing ctl_hven, or clearing both mode bits, returns the sequencer to ST_IDLE with all controls low. A new operation then needs a fresh mode selection and protect-byte read.
- R11: If the target address becomes protected while in ST_HV, hven_o drops after the next clock edge, viol_o is set and the sequencer goes to ST_BLOCKED.
- R12: A nvm_load pulse replaces the protect byte with nvm_data.
- R13: pgm_o and erase_o are never both 1, and hven_o is 1 only with exactly one of them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nvm_load | input | 1 | Load protect byte from storage |
| nvm_data | input | 8 | Protect byte value from storage |
| ctl_wr | input | 1 | Control write strobe |
| ctl_pgm | input | 1 | Program-mode bit of the write |
| ctl_erase | input | 1 | Erase-mode bit of the write |
| ctl_hven | input | 1 | High-voltage request bit of the write |
| prot_rd | input | 1 | Protect byte was read |
| tgt_addr | input | 16 | Target flash address |
| hv_test | input | 1 | External test-voltage condition present |
| op_commit | input | 1 | Flash operation completes this cycle |
| op_data | input | 8 | Data being programmed |
| viol_clr | input | 1 | Write-one-to-clear of the violation flag |
| pgm_o | output | 1 | Program mode active |
| erase_o | output | 1 | Erase mode active |
| hven_o | output | 1 | High-voltage enable |
| prot_byte_o | output | 8 | Current protect byte |
| prot_start_o | output | 16 | Protected window start address |
| tgt_prot_o | output | 1 | Target address is protected |
| viol_o | output | 1 | Sticky refusal flag |

## Verification
The range comparison is probed at the edges of the window: exactly at the start address, one below it, at 16'hFFFF, and with the two special byte values. An off-by-one comparator would grant the first protected address, and missing special cases would protect part of memory at 8'hFF or leave low memory open at 8'h00. The sequencing tests request high voltage without a read, request it after the mode was cleared and set again, and request it from a blocked state after a read. A design that forgets the read requirement, or leaves the blocked state too early, would raise hven_o in one of these tests. Further tests move the target into protection while high voltage is on, program and erase the protect byte with and without the test voltage, and reset after a byte change. A design that caches the grant, or resets the protect byte, would show the wrong hven_o or prot_byte_o.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_ARMED,
        ST_HV,
        ST_ILLEGAL,
        ST_BLOCKED
    } fwp_state_e;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_PGM,
        MODE_ERASE,
        MODE_BOTH
    } fwp_mode_e;

    function automatic fwp_mode_e decode_mode(input logic pgm, input logic erase);
        fwp_mode_e m;
        unique case ({pgm, erase})
            2'b00:   m = MODE_NONE;
            2'b10:   m = MODE_PGM;
            2'b01:   m = MODE_ERASE;
            default: m = MODE_BOTH;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fwp_range.sv
module fwp_range #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LOW_W  = 6
) (
    input  logic [BYTE_W-1:0] prot_byte,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] start,
    output logic              in_range
);
    localparam int HIGH_W = ADDR_W - BYTE_W - LOW_W;

    logic all_ones;
    logic all_zeros;

    assign all_ones  = &prot_byte;
    assign all_zeros = ~|prot_byte;
    assign start     = {{HIGH_W{1'b1}}, prot_byte, {LOW_W{1'b0}}};

    always_comb begin
        if (all_ones) begin
            in_range = 1'b0;
        end else if (all_zeros) begin
            in_range = 1'b1;
        end else begin
            in_range = (addr >= start);
        end
    end
endmodule

// File: rtl/fwp_store.sv
module fwp_store #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              load_vld,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              wr_pgm,
    input  logic              wr_erase,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] value
);
    logic [BYTE_W-1:0] value_q;

    // Non-volatile image: deliberately outside the reset domain.
    always_ff @(posedge clk) begin
        if (load_vld) begin
            value_q <= load_data;
        end else if (wr_erase) begin
            value_q <= {BYTE_W{1'b1}};
        end else if (wr_pgm) begin
            value_q <= value_q & wr_data;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/fwp_seq.sv
module fwp_seq
    import fwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_pgm,
    input  logic ctl_erase,
    input  logic ctl_hven,
    input  logic prot_rd,
    input  logic grant,
    output logic pgm_o,
    output logic erase_o,
    output logic hven_o,
    output logic refuse
);
    fwp_state_e st_q, st_d;
    fwp_mode_e  mode_q, mode_d;
    fwp_mode_e  wmode;

    assign wmode = decode_mode(ctl_pgm, ctl_erase);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_NONE;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        refuse = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ctl_wr) begin
                    unique case (wmode)
                        MODE_NONE: begin
                            refuse = ctl_hven;
                        end
                        MODE_BOTH: begin
                            st_d   = ST_ILLEGAL;
                            mode_d = MODE_BOTH;
                            refuse = ctl_hven;
                        end
                        default: begin
                            mode_d = wmode;
                            if (ctl_hven) begin
                                refuse = 1'b1;
                                st_d   = ST_BLOCKED;
                            end else begin
                                st_d = ST_MODE;
                            end
                        end
                    endcase
                end
            end
            ST_MODE: begin
                if (ctl_wr) begin
                    unique case (wmode)
                        MODE_NONE: begin
                            st_d   = ST_IDLE;
                            mode_d = MODE_NONE;
                        end
                        MODE_BOTH: begin
                            st_d   = ST_ILLEGAL;
                            mode_d = MODE_BOTH;
                            refuse = ctl_hven;
                        end
                        default: begin
                            mode_d = wmode;
                            if (ctl_hven) begin
                                refuse = 1'b1;
                                st_d   = ST_BLOCKED;
                            end
                        end
                    endcase
                end else if (prot_rd) begin
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (ctl_wr) begin
                    unique case (wmode)
                        MODE_NONE: begin
                            st_d   = ST_IDLE;
                            mode_d = MODE_NONE;
                        end
                        MODE_BOTH: begin
                            st_d   = ST_ILLEGAL;
                            mode_d = MODE_BOTH;
                            refuse = ctl_hven;
                        end
                        default: begin
                            if (wmode != mode_q) begin
                                mode_d = wmode;
                                if (ctl_hven) begin
                                    refuse = 1'b1;
                                    st_d   = ST_BLOCKED;
                                end else begin
                                    st_d = ST_MODE;
                                end
                            end else if (ctl_hven) begin
                                if (grant) begin
                                    st_d = ST_HV;
                                end else begin
                                    refuse = 1'b1;
                                    st_d   = ST_BLOCKED;
                                end
                            end
                        end
                    endcase
                end
            end
            ST_HV: begin
                if (ctl_wr && (wmode == MODE_NONE || !ctl_hven)) begin
                    st_d   = ST_IDLE;
                    mode_d = MODE_NONE;
                end else if (ctl_wr && wmode == MODE_BOTH) begin
                    st_d   = ST_ILLEGAL;
                    mode_d = MODE_BOTH;
                    refuse = 1'b1;
                end else if (!grant) begin
                    refuse = 1'b1;
                    st_d   = ST_BLOCKED;
                end else if (ctl_wr && wmode != mode_q) begin
                    refuse = 1'b1;
                    mode_d = wmode;
                    st_d   = ST_BLOCKED;
                end
            end
            ST_ILLEGAL: begin
                if (ctl_wr) begin
                    if (wmode == MODE_NONE) begin
                        st_d   = ST_IDLE;
                        mode_d = MODE_NONE;
                    end else begin
                        refuse = ctl_hven;
                    end
                end
            end
            ST_BLOCKED: begin
                if (ctl_wr) begin
                    unique case (wmode)
                        MODE_NONE: begin
                            st_d   = ST_IDLE;
                            mode_d = MODE_NONE;
                        end
                        MODE_BOTH: begin
                            st_d   = ST_ILLEGAL;
                            mode_d = MODE_BOTH;
                            refuse = ctl_hven;
                        end
                        default: begin
                            mode_d = wmode;
                            refuse = ctl_hven;
                        end
                    endcase
                end
            end
            default: begin
                st_d   = ST_IDLE;
                mode_d = MODE_NONE;
            end
        endcase
    end

    always_comb begin
        pgm_o   = (mode_q == MODE_PGM);
        erase_o = (mode_q == MODE_ERASE);
        hven_o  = (st_q == ST_HV);
    end
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl #(
    parameter int          ADDR_W    = 16,
    parameter int          BYTE_W    = 8,
    parameter int          LOW_W     = 6,
    parameter logic [15:0] BYTE_ADDR = 16'hFFCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvm_load,
    input  logic [BYTE_W-1:0] nvm_data,
    input  logic              ctl_wr,
    input  logic              ctl_pgm,
    input  logic              ctl_erase,
    input  logic              ctl_hven,
    input  logic              prot_rd,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              hv_test,
    input  logic              op_commit,
    input  logic [BYTE_W-1:0] op_data,
    input  logic              viol_clr,
    output logic              pgm_o,
    output logic              erase_o,
    output logic              hven_o,
    output logic [BYTE_W-1:0] prot_byte_o,
    output logic [ADDR_W-1:0] prot_start_o,
    output logic              tgt_prot_o,
    output logic              viol_o
);
    localparam logic [ADDR_W-1:0] SELF_ADDR = ADDR_W'(BYTE_ADDR);

    logic [BYTE_W-1:0] byte_q;
    logic              in_range;
    logic              at_self;
    logic              grant;
    logic              refuse;
    logic              self_wr;
    logic              viol_q;

    fwp_range #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LOW_W(LOW_W)) u_range (
        .prot_byte (byte_q),
        .addr      (tgt_addr),
        .start     (prot_start_o),
        .in_range  (in_range)
    );

    assign at_self = (tgt_addr == SELF_ADDR);
    assign grant   = in_range ? (hv_test && at_self) : 1'b1;

    fwp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_pgm   (ctl_pgm),
        .ctl_erase (ctl_erase),
        .ctl_hven  (ctl_hven),
        .prot_rd   (prot_rd),
        .grant     (grant),
        .pgm_o     (pgm_o),
        .erase_o   (erase_o),
        .hven_o    (hven_o),
        .refuse    (refuse)
    );

    assign self_wr = op_commit && hven_o && at_self && grant;

    fwp_store #(.BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .load_vld  (nvm_load),
        .load_data (nvm_data),
        .wr_pgm    (self_wr && pgm_o),
        .wr_erase  (self_wr && erase_o),
        .wr_data   (op_data),
        .value     (byte_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (refuse) begin
            viol_q <= 1'b1;
        end else if (viol_clr) begin
            viol_q <= 1'b0;
        end
    end

    assign prot_byte_o = byte_q;
    assign tgt_prot_o  = in_range;
    assign viol_o      = viol_q;
endmodule

// File: rtl/fwp_ctrl_chk.sv
module fwp_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic        ctl_hven,
    input logic        hv_test,
    input logic [15:0] tgt_addr,
    input logic        pgm_o,
    input logic        erase_o,
    input logic        hven_o,
    input logic [7:0]  prot_byte_o,
    input logic        tgt_prot_o,
    input logic        viol_o
);
    // R13
    modes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_o && erase_o));

    // R13
    hv_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hven_o |-> (pgm_o ^ erase_o));

    // R4
    hv_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hven_o |-> $past(!tgt_prot_o || (hv_test && tgt_addr == 16'hFFCF)));

    // R5
    hv_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hven_o) |-> $past(ctl_wr && ctl_hven));

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_o) |-> ($past(ctl_wr && ctl_hven) || $past(hven_o)));

    // R2
    blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_byte_o == 8'hFF) |-> !tgt_prot_o);

    // R3
    zero_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_byte_o == 8'h00) |-> tgt_prot_o);
endmodule

bind fwp_ctrl fwp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_hven    (ctl_hven),
    .hv_test     (hv_test),
    .tgt_addr    (tgt_addr),
    .pgm_o       (pgm_o),
    .erase_o     (erase_o),
    .hven_o      (hven_o),
    .prot_byte_o (prot_byte_o),
    .tgt_prot_o  (tgt_prot_o),
    .viol_o      (viol_o)
);

// File: tb/fwp_ctrl_tb.sv
module fwp_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nvm_load = 1'b0;
    logic [7:0]  nvm_data = 8'h00;
    logic        ctl_wr = 1'b0, ctl_pgm = 1'b0, ctl_erase = 1'b0, ctl_hven = 1'b0;
    logic        prot_rd = 1'b0;
    logic [15:0] tgt_addr = 16'h0000;
    logic        hv_test = 1'b0;
    logic        op_commit = 1'b0;
    logic [7:0]  op_data = 8'h00;
    logic        viol_clr = 1'b0;
    logic        pgm_o, erase_o, hven_o, tgt_prot_o, viol_o;
    logic [7:0]  prot_byte_o;
    logic [15:0] prot_start_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fwp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nvm_load(nvm_load), .nvm_data(nvm_data),
        .ctl_wr(ctl_wr), .ctl_pgm(ctl_pgm), .ctl_erase(ctl_erase), .ctl_hven(ctl_hven),
        .prot_rd(prot_rd), .tgt_addr(tgt_addr), .hv_test(hv_test),
        .op_commit(op_commit), .op_data(op_data), .viol_clr(viol_clr),
        .pgm_o(pgm_o), .erase_o(erase_o), .hven_o(hven_o),
        .prot_byte_o(prot_byte_o), .prot_start_o(prot_start_o),
        .tgt_prot_o(tgt_prot_o), .viol_o(viol_o)
    );

    // {protect byte, address, expected protected}
    localparam logic [24:0] VEC [14] = '{
        {8'hFF, 16'hFFFF, 1'b0}, {8'hFF, 16'h0000, 1'b0},
        {8'h00, 16'h0000, 1'b1}, {8'h00, 16'h8000, 1'b1},
        {8'h80, 16'hE000, 1'b1}, {8'h80, 16'hDFFF, 1'b0},
        {8'h01, 16'hC040, 1'b1}, {8'h01, 16'hC03F, 1'b0},
        {8'hFE, 16'hFF80, 1'b1}, {8'hFE, 16'hFF7F, 1'b0},
        {8'hFE, 16'hFFFF, 1'b1}, {8'h3C, 16'hCF00, 1'b1},
        {8'h3C, 16'hCEFF, 1'b0}, {8'h80, 16'h0000, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] b);
        nvm_load = 1'b1; nvm_data = b;
        @(negedge clk);
        nvm_load = 1'b0;
    endtask

    task automatic wr(input logic p, input logic e, input logic h);
        ctl_wr = 1'b1; ctl_pgm = p; ctl_erase = e; ctl_hven = h;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_pgm = 1'b0; ctl_erase = 1'b0; ctl_hven = 1'b0;
    endtask

    task automatic rd();
        prot_rd = 1'b1;
        @(negedge clk);
        prot_rd = 1'b0;
    endtask

    task automatic clr();
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
    endtask

    task automatic commit(input logic [7:0] d);
        op_commit = 1'b1; op_data = d;
        @(negedge clk);
        op_commit = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        load(8'h5A);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 byte kept", prot_byte_o, 8'h5A);
        chk("R8 controls", {pgm_o, erase_o, hven_o, viol_o}, 4'b0000);

        // R1 R2 R3 window vectors
        for (int i = 0; i < 14; i++) begin
            load(VEC[i][24:17]);
            tgt_addr = VEC[i][16:1];
            #1;
            chk("R1/R2/R3 window", tgt_prot_o, VEC[i][0]);
            chk("R1 start", prot_start_o, {2'b11, VEC[i][24:17], 6'b0});
        end

        // R12 load
        load(8'hFF);
        chk("R12 load", prot_byte_o, 8'hFF);

        // normal program, then R10
        tgt_addr = 16'h1000;
        wr(1, 0, 0);
        chk("R10 mode set", {pgm_o, erase_o, hven_o}, 3'b100);
        rd();
        wr(1, 0, 1);
        chk("R4 granted", {hven_o, viol_o}, 2'b10);
        wr(1, 0, 0);
        chk("R10 hven clear idle", {pgm_o, hven_o}, 2'b00);
        // R5 request without read
        wr(1, 0, 1);
        chk("R5 no read", {hven_o, viol_o}, 2'b01);
        rd();
        wr(1, 0, 1);
        chk("R5 still blocked", {pgm_o, hven_o}, 2'b10);
        // R9 clear races refusal
        ctl_wr = 1'b1; ctl_pgm = 1'b1; ctl_hven = 1'b1; viol_clr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_pgm = 1'b0; ctl_hven = 1'b0; viol_clr = 1'b0;
        chk("R9 set wins", viol_o, 1'b1);
        wr(0, 0, 0);
        clr();
        chk("R9 cleared", viol_o, 1'b0);

        // R4 protected target
        load(8'h80);
        tgt_addr = 16'hE000;
        wr(0, 1, 0); rd(); wr(0, 1, 1);
        chk("R4 refused", {hven_o, viol_o}, 2'b01);
        wr(0, 0, 0); clr();
        tgt_addr = 16'hDFFF;
        wr(0, 1, 0); rd(); wr(0, 1, 1);
        chk("R4 below start", {erase_o, hven_o, viol_o}, 3'b110);
        // R11 target moves
        tgt_addr = 16'hE000;
        @(negedge clk);
        chk("R11 drop", {hven_o, viol_o}, 2'b01);
        wr(0, 0, 0); clr();

        // R6 illegal
        tgt_addr = 16'h1000;
        wr(1, 1, 0);
        chk("R6 outputs", {pgm_o, erase_o, hven_o}, 3'b000);
        rd(); wr(1, 1, 1);
        chk("R6 refused", {hven_o, viol_o}, 2'b01);
        wr(0, 0, 0); clr();

        // R7 protect byte itself
        tgt_addr = 16'hFFCF;
        wr(1, 0, 0); rd(); wr(1, 0, 1);
        chk("R7 no test voltage", {hven_o, viol_o}, 2'b01);
        wr(0, 0, 0); clr();
        hv_test = 1'b1;
        wr(1, 0, 0); rd(); wr(1, 0, 1);
        chk("R7 test voltage", hven_o, 1'b1);
        commit(8'h0F);
        chk("R7 program AND", prot_byte_o, 8'h00);
        wr(0, 0, 0);
        wr(0, 1, 0); rd(); wr(0, 1, 1);
        commit(8'h00);
        chk("R7 erase", prot_byte_o, 8'hFF);
        wr(0, 0, 0);
        hv_test = 1'b0;
        wr(1, 0, 0); rd(); wr(1, 0, 1);
        commit(8'h7E);
        chk("R7 blank byte programmable", prot_byte_o, 8'h7E);
        wr(0, 0, 0);

        // R8 reset mid-run keeps byte
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 byte after reset", prot_byte_o, 8'h7E);
        chk("R8 idle after reset", {pgm_o, erase_o, hven_o, viol_o}, 4'b0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule